// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the sequence of column addresses that an SDRAM controller drives on its address pins, one per beat. A request carries a starting column, a read or write flag, and the mode settings that were programmed into the memory: a length code, an ordering bit (linear or interleaved), and a write-single bit that makes writes touch only one location while reads keep the full length. The block presents one address per clock with a valid strobe, marks the final beat, and flags requests whose length code is not a legal combination.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block of that size that holds the starting column. Linear order counts upward and wraps within the block. Interleaved order forms each address as the starting column XOR the beat number. A whole-row burst counts upward from the start, wraps around the full row, and runs until the controller asserts a terminate input. Mode inputs are sampled when a request is accepted, so the controller may change them while a burst is running.

Top module: `sdr_burst_colgen`

## Requirements
- R1: While reset is held and after its release with no request, `beat_vld_o`, `last_o` and `rsvd_err_o` are low.
- R2: A request is accepted on a clock edge where `start_i` is high and no burst is running; the first beat appears in the next cycle with `col_o` equal to the start column, and further beats follow on consecutive cycles with no gap.
- R3: Length code `len_code_i` 3'b000, 3'b001, 3'b010, 3'b011 gives exactly 1, 2, 4, 8 beats, and `last_o` is high on the final beat only; the cycle after the final beat has `beat_vld_o` low.
- R4: With `ilv_i`=0 and a fixed length N, beat i has address (start rounded down to a multiple of N) + ((start mod N + i) mod N).
- R5: With `ilv_i`=1 and a fixed length N, beat i has address start XOR i.
- R6: Length code 3'b111 with `ilv_i`=0 is a whole-row burst: beat i has address (start + i) mod 2^COL_W; the beat during which `stop_i` is high is the final one and carries `last_o`, and no beat follows it.
- R7: Length codes 3'b100, 3'b101, 3'b110, and 3'b111 with `ilv_i`=1, are reserved: the burst is a single beat at the start column with `rsvd_err_o` high on that beat; this takes precedence over R8.
- R8: When `is_write_i`=1 and `wr_single_i`=1 at acceptance, the burst is one beat at the start column; with `is_write_i`=0 the `wr_single_i` bit has no effect on length.
- R9: `start_i` while a burst is running is ignored, and `stop_i` is ignored during fixed-length bursts.
- R10: Changes on `start_col_i`, `len_code_i`, `ilv_i`, `is_write_i` and `wr_single_i` after acceptance do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Burst request |
| start_col_i | input | COL_W | Starting column of the burst |
| is_write_i | input | 1 | 1 = write burst, 0 = read burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 0 = linear order, 1 = interleaved order |
| wr_single_i | input | 1 | Writes access a single column when high |
| stop_i | input | 1 | Terminates a whole-row burst on the current beat |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one |
| rsvd_err_o | output | 1 | Current burst used a reserved length code |

## Verification
The assertions assume that `stop_i` is a same-cycle input sampled only while a whole-row burst is running, and that requests are held for at least one edge where the block is idle; they rely on no ordering between `start_i` and the mode fields beyond both being valid at the accepting edge. The stimulus drives every input half a cycle away from the rising edge, presents each request only while idle, and then scrambles all request and mode inputs, including `start_i` and `stop_i` during fixed bursts, for the rest of the burst so that sampling at acceptance is exercised. A queue-based model predicts every beat for all length codes, both orders, all read/write and write-single combinations, and start columns covering every offset within an eight-column block, plus whole-row bursts that cross the row end.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // Width of the log2 of the longest fixed burst (8 beats -> 3, fits in 2 bits).
  localparam int unsigned LG_W      = 2;
  localparam int unsigned LEN_W     = 3;

  localparam logic [LEN_W-1:0] LEN_ONE = 3'b000;
  localparam logic [LEN_W-1:0] LEN_TWO = 3'b001;
  localparam logic [LEN_W-1:0] LEN_FOUR = 3'b010;
  localparam logic [LEN_W-1:0] LEN_EIGHT = 3'b011;
  localparam logic [LEN_W-1:0] LEN_ROW = 3'b111;

  // Settings captured when a burst is accepted.
  typedef struct packed {
    logic [LG_W-1:0] lg;   // log2 of the fixed beat count
    logic            row;  // whole-row burst, ended by stop
    logic            ilv;  // interleaved ordering
    logic            err;  // reserved length code seen
  } burst_cfg_t;

endpackage

// File: rtl/sbc_mode_decode.sv
module sbc_mode_decode
  import sbc_pkg::*;
(
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             ilv_i,
  input  logic             is_write_i,
  input  logic             wr_single_i,
  output burst_cfg_t       cfg_o
);

  logic rsvd;
  logic fixed_code;

  always_comb begin
    fixed_code = (len_code_i == LEN_ONE) || (len_code_i == LEN_TWO) ||
                 (len_code_i == LEN_FOUR) || (len_code_i == LEN_EIGHT);
    // Whole-row length is only legal with linear ordering.
    rsvd       = !fixed_code && !((len_code_i == LEN_ROW) && !ilv_i);
  end

  always_comb begin
    cfg_o     = '0;
    cfg_o.ilv = ilv_i;
    if (rsvd) begin
      cfg_o.err = 1'b1;
    end else if (is_write_i && wr_single_i) begin
      cfg_o.lg  = '0;
    end else if (len_code_i == LEN_ROW) begin
      cfg_o.row = 1'b1;
    end else begin
      cfg_o.lg  = len_code_i[LG_W-1:0];
    end
  end

endmodule

// File: rtl/sbc_addr_gen.sv
module sbc_addr_gen
  import sbc_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [LG_W-1:0]  lg_i,
  input  logic             row_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] lin_col;
  logic [COL_W-1:0] ilv_col;

  // Bits below log2(length) move during a burst; a row burst moves them all.
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign wrap_mask[b] = row_i || (b < int'(lg_i));
  end

  always_comb begin
    lin_col = (base_i & ~wrap_mask) | ((base_i + idx_i) & wrap_mask);
    ilv_col = base_i ^ (idx_i & wrap_mask);
    col_o   = ilv_i ? ilv_col : lin_col;
  end

endmodule

// File: rtl/sbc_beat_ctrl.sv
module sbc_beat_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  burst_cfg_t       cfg_i,
  input  logic [COL_W-1:0] col_i,
  output logic             busy_o,
  output logic             final_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] base_o,
  output burst_cfg_t       cfg_o
);

  logic             busy_q, busy_d;
  logic [COL_W-1:0] idx_q, idx_d;
  logic [COL_W-1:0] base_q, base_d;
  burst_cfg_t       cfg_q, cfg_d;
  logic [COL_W-1:0] last_idx;
  logic             load;
  logic             fin;
  logic             en;

  for (genvar b = 0; b < COL_W; b++) begin : g_last
    assign last_idx[b] = (b < int'(cfg_q.lg));
  end

  always_comb begin
    load = start_i && !busy_q;
    fin  = busy_q && (cfg_q.row ? stop_i : (idx_q == last_idx));
    en   = load || busy_q;
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    base_d = base_q;
    cfg_d  = cfg_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
      base_d = col_i;
      cfg_d  = cfg_i;
    end else if (busy_q) begin
      idx_d  = idx_q + 1'b1;
      if (fin) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      cfg_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      base_q <= base_d;
      cfg_q  <= cfg_d;
    end
  end

  assign busy_o  = busy_q;
  assign final_o = fin;
  assign idx_o   = idx_q;
  assign base_o  = base_q;
  assign cfg_o   = cfg_q;

  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fin) |=> (busy_q && idx_q == $past(idx_q) + 1'b1)); // R2

  AST_END_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> !busy_q); // R3

  AST_FIXED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !cfg_q.row) |-> (idx_q <= last_idx)); // R3

  AST_BASE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$past(fin)) |-> $stable(base_q)); // R10

endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
  import sbc_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             is_write_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             last_o,
  output logic             rsvd_err_o
);

  localparam int unsigned FIX_MAX_LG = 3;

  logic             rst_meta_q, rst_sync_q;
  burst_cfg_t       req_cfg;
  burst_cfg_t       run_cfg;
  logic             busy;
  logic             fin;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] base;

  // Reset asserts at once and deasserts after two clock edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sbc_mode_decode u_decode (
    .len_code_i  (len_code_i),
    .ilv_i       (ilv_i),
    .is_write_i  (is_write_i),
    .wr_single_i (wr_single_i),
    .cfg_o       (req_cfg)
  );

  sbc_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .start_i (start_i),
    .stop_i  (stop_i),
    .cfg_i   (req_cfg),
    .col_i   (start_col_i),
    .busy_o  (busy),
    .final_o (fin),
    .idx_o   (idx),
    .base_o  (base),
    .cfg_o   (run_cfg)
  );

  sbc_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base),
    .idx_i  (idx),
    .lg_i   (run_cfg.lg),
    .row_i  (run_cfg.row),
    .ilv_i  (run_cfg.ilv),
    .col_o  (col_o)
  );

  assign beat_vld_o = busy;
  assign last_o     = fin;
  assign rsvd_err_o = busy && run_cfg.err;

  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (start_i && !beat_vld_o) |=> (beat_vld_o && col_o == $past(start_col_i))); // R2

  AST_ERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    rsvd_err_o |-> last_o); // R7

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (start_i && !beat_vld_o && is_write_i && wr_single_i) |=> last_o); // R8

  AST_BLOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (beat_vld_o && $past(beat_vld_o) && !$past(last_o) && !run_cfg.row) |->
    (col_o[COL_W-1:FIX_MAX_LG] == $past(col_o[COL_W-1:FIX_MAX_LG]))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !beat_vld_o |-> (!last_o && !rsvd_err_o)); // R1

endmodule

// File: tb/sdr_burst_colgen_tb_top.sv
module sdr_burst_colgen_tb_top;

  localparam int COL_W = 8;
  localparam int ROW   = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [COL_W-1:0] start_col;
  logic             is_wr;
  logic [2:0]       len_code;
  logic             ilv;
  logic             wr_single;
  logic             stop;
  logic [COL_W-1:0] col;
  logic             vld;
  logic             last;
  logic             err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sdr_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .start_col_i (start_col),
    .is_write_i  (is_wr),
    .len_code_i  (len_code),
    .ilv_i       (ilv),
    .wr_single_i (wr_single),
    .stop_i      (stop),
    .col_o       (col),
    .beat_vld_o  (vld),
    .last_o      (last),
    .rsvd_err_o  (err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(vld == 1'b0, req, "beat_vld idle", int'(vld), 0);
    chk(last == 1'b0, req, "last idle", int'(last), 0);
    chk(err == 1'b0, req, "err idle", int'(err), 0);
  endtask

  // One burst: request while idle, then scramble inputs and compare each beat.
  task automatic run_burst(input int c0, input int code, input int il,
                           input int wr, input int ws, input int stop_at);
    int   exp_q[$];
    bit   rsv, row, single;
    int   nb, n, blk, e;
    string req;
    rsv    = (code >= 4 && code <= 6) || (code == 7 && il == 1);
    single = rsv || (wr == 1 && ws == 1);
    row    = !single && code == 7;
    n      = single ? 1 : (row ? ROW : (1 << code));
    nb     = row ? stop_at + 1 : n;
    blk    = c0 - (c0 % n);
    for (int i = 0; i < nb; i++) begin
      if (row)          exp_q.push_back((c0 + i) % ROW);
      else if (il == 1) exp_q.push_back(c0 ^ i);
      else              exp_q.push_back(blk + ((c0 % n) + i) % n);
    end
    if (rsv)                 req = "R7";
    else if (wr == 1 && ws == 1) req = "R8";
    else if (row)            req = "R6";
    else if (il == 1)        req = "R5 R3";
    else                     req = "R4 R3";

    @(negedge clk);
    start     = 1'b1;
    start_col = COL_W'(c0);
    len_code  = 3'(code);
    ilv       = il[0];
    is_wr     = wr[0];
    wr_single = ws[0];
    stop      = 1'b0;
    #1;
    chk(vld == 1'b0, "R2", "idle before accept", int'(vld), 0);
    @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      // R10 and R9: everything scrambled after acceptance, start held busy.
      start     = 1'($urandom);
      start_col = COL_W'($urandom);
      len_code  = 3'($urandom);
      ilv       = 1'($urandom);
      is_wr     = 1'($urandom);
      wr_single = 1'($urandom);
      stop      = row ? (i == stop_at) : 1'($urandom);
      #1;
      e = exp_q.pop_front();
      chk(vld == 1'b1, "R2 R10", "beat_vld", int'(vld), 1);
      chk(int'(col) == e, req, "col", int'(col), e);
      chk(last == (i == nb - 1), req, "last", int'(last), int'(i == nb - 1));
      chk(err == rsv, "R7", "rsvd_err", int'(err), int'(rsv));
      @(negedge clk);
    end
    start = 1'b0;
    stop  = 1'b0;
    #1;
    chk(vld == 1'b0, "R3 R9", "no beat after final", int'(vld), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_col = '0; is_wr = 1'b0;
    len_code = '0; ilv = 1'b0; wr_single = 1'b0; stop = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk_idle("R1");

    // Every length code, order and write mode; starts cover all offsets mod 8.
    for (int code = 0; code < 8; code++)
      for (int il = 0; il < 2; il++)
        for (int m = 0; m < 4; m++)
          for (int c = 0; c < ROW; c += 3)
            run_burst(c, code, il, m[1], m[0], c % 4);

    // Whole-row bursts crossing the row end, short and long.
    run_burst(0,   7, 0, 0, 0, 0);
    run_burst(250, 7, 0, 0, 0, 12);
    run_burst(255, 7, 0, 1, 0, 300);
    run_burst(100, 7, 0, 0, 1, ROW);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule